// File: doc/BRIEF.md
# Static Memory Chip-Select Timing Controller

This block sequences one access at a time to external static memories on up to eight chip selects. Each chip select has its own configuration word. The word holds a wait-state count and its enable bit, a choice between two read-strobe protocols, a bus width of 8 or 16 bits, a wiring choice for 16-bit buses, and a turnaround (data-float) count. When a request is accepted, the block pulls the selected chip-select line low. It drives the read strobe, or the per-lane write strobes, and the byte-lane selects for the programmed length. It then returns a one-cycle done pulse that carries the captured read data.

The block runs on a clock at twice the bus rate, so every strobe length is a whole number of fast-clock periods and half bus cycles come out exactly. After each access, the data-float count holds the bus reserved for that many bus cycles. During this time only the chip select that just finished may start again. A request to any other chip select waits until the turnaround has expired.

Top module: `static_cs_timing`

## Requirements
- R1: After reset every chip-select line, the read strobe, both write strobes and both byte-lane selects are high. done is 0, rd_data is 0, every configuration word reads 0 and req_ready is 1.
- R2: The configuration word layout is: bits 6:0 wait count X, bit 7 wait enable, bits 11:8 float count F, bit 12 wide bus (1 = 16-bit), bit 13 whole-device (1 = one 16-bit device), bit 14 early read. Bit 15 always reads 0. When bit 7 reads 0, bits 6:0 read 0 whatever was written.
- R3: With the standard protocol (bit 14 = 0), the read strobe is low for 2X+3 fast-clock periods when wait states are enabled, and for 1 period when they are not.
- R4: With the early protocol (bit 14 = 1), the read strobe is low for 2X+4 periods when wait states are enabled, and for 2 periods when they are not.
- R5: A write strobe is low for 2X+2 periods when wait states are enabled. When they are not, it is low for 2 periods under the early protocol and 1 period under the standard protocol.
- R6: During an access exactly the requested chip-select line (mem_cs_n bit = index) is low, for the whole strobe and only then, and mem_addr/mem_dout hold the request's address and data.
- R7: On a 16-bit bus with whole-device = 0, a write drives mem_we_n[i] low only for the lanes i whose req_be[i] is 1, and mem_bsel_n stays 11.
- R8: On a 16-bit bus with whole-device = 1, a write uses only mem_we_n[0] (mem_we_n = 10), and mem_bsel_n = ~req_be during the strobe of both reads and writes.
- R9: On an 8-bit bus, a write uses mem_we_n[0] only and mem_bsel_n stays 11, whatever req_be and whole-device hold. The read data's upper byte is returned as 0.
- R10: done is high for exactly the one cycle after the last strobe cycle. After a read, rd_data then holds mem_din as sampled in that last strobe cycle. A write leaves rd_data unchanged.
- R11: After an access whose float count is F ends, req_ready is 0 for 2F cycles, starting with the done cycle, for any other chip-select index.
- R12: A request to the same chip select as the previous access is ready from the done cycle onward, whatever remains of the float period.
- R13: req_ready is 0 while an access is in progress. A request is accepted on a clock edge where req_valid and req_ready are both 1, and its strobe starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the bus rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 3 | Chip-select index for configuration write and readback |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Readback of the word at cfg_idx |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Controller can accept the request |
| req_cs | input | 3 | Target chip-select index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data |
| mem_addr | output | 16 | Address to memory |
| mem_dout | output | 16 | Data to memory |
| mem_din | input | 16 | Data from memory |
| mem_cs_n | output | 8 | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 2 | Active-low per-lane write strobes |
| mem_bsel_n | output | 2 | Active-low byte-lane selects |

## Verification
The bench sets the wait-count limits (0, small values, 127) against each protocol and each direction. An off-by-one in the half-cycle arithmetic shows up as a strobe one period too long or too short. It probes req_ready in the done cycle for the same and for a different chip select. A design that keyed the turnaround on the bus alone would stall the same-select request, and one that skipped the turnaround would let the other select in early. The three lane wirings are driven with partial byte enables: a mixed-up lane decode fires the wrong write strobe or asserts byte selects on a pair of 8-bit devices. A disabled wait count with nonzero bits stored is read back to catch a design that returns the stale field.

// File: rtl/scs_pkg.sv
package scs_pkg;
   localparam int WS_W  = 7;
   localparam int FLT_W = 4;
   localparam int CFG_W = 16;
   localparam int LEN_W = WS_W + 2;

   typedef struct packed {
      logic             early_rd;
      logic             whole_dev;
      logic             wide_bus;
      logic [FLT_W-1:0] float_cyc;
      logic             ws_en;
      logic [WS_W-1:0]  ws_cnt;
   } cs_cfg_t;

   localparam int CFG_USED = $bits(cs_cfg_t);
endpackage

// File: rtl/scs_cfg_bank.sv
module scs_cfg_bank
   import scs_pkg::*;
#(
   parameter int NUM_CS = 8,
   parameter int CSW    = $clog2(NUM_CS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CSW-1:0]   wr_idx,
   input  logic [CFG_W-1:0] wr_word,
   output logic [CFG_W-1:0] rd_word,
   input  logic [CSW-1:0]   sel_idx,
   output cs_cfg_t          sel_cfg
);
   if (CFG_USED > CFG_W) begin : g_bad_layout
      $error("configuration fields exceed word width");
   end

   cs_cfg_t cfg_all [NUM_CS];

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      cs_cfg_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr_en && (wr_idx == CSW'(g))) begin
            q <= cs_cfg_t'(wr_word[CFG_USED-1:0]);
         end
      end
      assign cfg_all[g] = q;
   end

   cs_cfg_t view;
   always_comb begin
      view = cfg_all[wr_idx];
      if (!view.ws_en) begin
         view.ws_cnt = '0;
      end
   end
   assign rd_word = {{(CFG_W-CFG_USED){1'b0}}, view};
   assign sel_cfg = cfg_all[sel_idx];

   // R2: a written word with wait enable set reads back unchanged (bit 15 cleared)
   assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_word[7]) |=>
         (!$stable(wr_idx) || rd_word == {1'b0, $past(wr_word[CFG_W-2:0])}));
endmodule

// File: rtl/scs_pulse_len.sv
module scs_pulse_len
   import scs_pkg::*;
(
   input  cs_cfg_t          cfg,
   input  logic             is_write,
   output logic [LEN_W-1:0] len_m1
);
   logic [LEN_W-1:0] tail;
   logic [LEN_W-1:0] len;

   always_comb begin
      tail = cfg.early_rd ? LEN_W'(2) : LEN_W'(1);
      if (cfg.ws_en) begin
         len = LEN_W'({cfg.ws_cnt, 1'b0}) + LEN_W'(2) + (is_write ? '0 : tail);
      end else begin
         len = tail;
      end
      len_m1 = len - LEN_W'(1);
   end
endmodule

// File: rtl/scs_float_ctr.sv
module scs_float_ctr
   import scs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [FLT_W-1:0] load_cyc,
   output logic             bus_free
);
   logic [FLT_W:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= {load_cyc, 1'b0};
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign bus_free = (cnt == '0);

   // R11: the turnaround counts down one fast period per cycle
   assert_float_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/static_cs_timing.sv
module static_cs_timing
   import scs_pkg::*;
#(
   parameter int NUM_CS = 8,
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   localparam int CSW   = $clog2(NUM_CS),
   localparam int LANES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CSW-1:0]    cfg_idx,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic [CFG_W-1:0]  cfg_rdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CSW-1:0]    req_cs,
   input  logic              req_write,
   input  logic [LANES-1:0]  req_be,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   input  logic [DATA_W-1:0] mem_din,
   output logic [NUM_CS-1:0] mem_cs_n,
   output logic              mem_rd_n,
   output logic [LANES-1:0]  mem_we_n,
   output logic [LANES-1:0]  mem_bsel_n
);
   if (DATA_W != 16) begin : g_bad_width
      $error("data bus must be 16 bits (two byte lanes)");
   end
   if (NUM_CS < 2 || NUM_CS > 8) begin : g_bad_cs
      $error("chip-select count must be 2 to 8");
   end

   cs_cfg_t          sel_cfg;
   logic [LEN_W-1:0] len_m1;
   logic             bus_free;

   logic             busy;
   logic [LEN_W-1:0] cnt;
   logic             cur_rd;
   logic             cur_wide;
   logic [FLT_W-1:0] cur_flt;
   logic [CSW-1:0]   last_cs;
   logic [LANES-1:0] nxt_we_n;
   logic [LANES-1:0] nxt_bsel_n;
   logic             accept;
   logic             finish;

   scs_cfg_bank #(.NUM_CS(NUM_CS), .CSW(CSW)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_idx  (cfg_idx),
      .wr_word (cfg_wdata),
      .rd_word (cfg_rdata),
      .sel_idx (req_cs),
      .sel_cfg (sel_cfg)
   );

   scs_pulse_len u_len (
      .cfg      (sel_cfg),
      .is_write (req_write),
      .len_m1   (len_m1)
   );

   assign finish = busy && (cnt == '0);

   scs_float_ctr u_float (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (finish),
      .load_cyc (cur_flt),
      .bus_free (bus_free)
   );

   assign req_ready = !busy && (bus_free || (req_cs == last_cs));
   assign accept    = req_valid && req_ready;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l == 0) begin : g_low
         assign nxt_we_n[l] = !(req_write &&
            (!sel_cfg.wide_bus || sel_cfg.whole_dev || req_be[l]));
      end else begin : g_high
         assign nxt_we_n[l] = !(req_write && sel_cfg.wide_bus &&
            !sel_cfg.whole_dev && req_be[l]);
      end
      assign nxt_bsel_n[l] = !(sel_cfg.wide_bus && sel_cfg.whole_dev && req_be[l]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         cnt        <= '0;
         cur_rd     <= 1'b0;
         cur_wide   <= 1'b0;
         cur_flt    <= '0;
         last_cs    <= '0;
         mem_cs_n   <= '1;
         mem_rd_n   <= 1'b1;
         mem_we_n   <= '1;
         mem_bsel_n <= '1;
         mem_addr   <= '0;
         mem_dout   <= '0;
         done       <= 1'b0;
         rd_data    <= '0;
      end else begin
         done <= 1'b0;
         if (busy) begin
            if (cnt == '0) begin
               busy       <= 1'b0;
               mem_cs_n   <= '1;
               mem_rd_n   <= 1'b1;
               mem_we_n   <= '1;
               mem_bsel_n <= '1;
               done       <= 1'b1;
               if (cur_rd) begin
                  rd_data <= cur_wide ? mem_din : {{(DATA_W-8){1'b0}}, mem_din[7:0]};
               end
            end else begin
               cnt <= cnt - 1'b1;
            end
         end else if (accept) begin
            busy       <= 1'b1;
            cnt        <= len_m1;
            cur_rd     <= !req_write;
            cur_wide   <= sel_cfg.wide_bus;
            cur_flt    <= sel_cfg.float_cyc;
            last_cs    <= req_cs;
            mem_cs_n   <= ~(NUM_CS'(1) << req_cs);
            mem_rd_n   <= req_write;
            mem_we_n   <= nxt_we_n;
            mem_bsel_n <= nxt_bsel_n;
            mem_addr   <= req_addr;
            mem_dout   <= req_wdata;
         end
      end
   end

   // R6: never more than one chip select active
   assert_one_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~mem_cs_n) <= 1);
   // R6: any strobe or lane select only inside a chip-select window
   assert_strobe_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_rd_n || mem_we_n != '1 || mem_bsel_n != '1) |-> (mem_cs_n != '1));
   // R10: completion pulse lasts one cycle
   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R13: no acceptance while an access is on the bus
   assert_busy_blocks_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs_n != '1) |-> !req_ready);
   // R13: an accepted request opens its chip select on the next cycle
   assert_accept_starts_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (mem_cs_n != '1));
endmodule

// File: tb/static_cs_timing_tb.sv
module static_cs_timing_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [2:0]  req_cs = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_be = '0;
   logic [15:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        done;
   logic [15:0] rd_data;
   logic [15:0] mem_addr;
   logic [15:0] mem_dout;
   logic [15:0] mem_din = '0;
   logic [7:0]  mem_cs_n;
   logic        mem_rd_n;
   logic [1:0]  mem_we_n;
   logic [1:0]  mem_bsel_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   static_cs_timing u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
      .req_ready(req_ready), .req_cs(req_cs), .req_write(req_write),
      .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
      .done(done), .rd_data(rd_data), .mem_addr(mem_addr), .mem_dout(mem_dout),
      .mem_din(mem_din), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
      .mem_we_n(mem_we_n), .mem_bsel_n(mem_bsel_n)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [15:0] m_cfg [8];
   bit          m_busy = 0;
   int          m_rem = 0;
   int          m_flt = 0;
   int          m_cur_flt = 0;
   bit          m_cur_rd = 0;
   bit          m_cur_wide = 0;
   logic [2:0]  m_last = '0;
   logic [7:0]  m_cs_n = '1;
   logic        m_rd_n = 1'b1;
   logic [1:0]  m_we_n = '1;
   logic [1:0]  m_bsel_n = '1;
   logic [15:0] m_addr = '0;
   logic        m_done = 1'b0;
   logic [15:0] m_rdata = '0;

   initial for (int i = 0; i < 8; i++) m_cfg[i] = '0;

   function automatic int plen(input logic [15:0] c, input bit wr);
      int x = int'(c[6:0]);
      if (!c[7]) return c[14] ? 2 : 1;
      if (wr) return 2*x + 2;
      return c[14] ? 2*x + 4 : 2*x + 3;
   endfunction

   function automatic bit m_ready();
      return !m_busy && (m_flt == 0 || req_cs == m_last);
   endfunction

   function automatic logic [15:0] m_view(input logic [15:0] c);
      logic [15:0] v = c & 16'h7FFF;
      if (!v[7]) v[6:0] = '0;
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 8; i++) m_cfg[i] = '0;
         m_busy = 0; m_rem = 0; m_flt = 0; m_last = '0; m_cs_n = '1; m_rd_n = 1;
         m_we_n = '1; m_bsel_n = '1; m_addr = '0; m_done = 0; m_rdata = '0;
      end else begin
         bit acc;
         bit ended;
         logic [15:0] c;
         acc = req_valid && m_ready();
         ended = 0;
         m_done = 0;
         if (m_busy) begin
            m_rem--;
            if (m_rem == 0) begin
               ended = 1;
               m_busy = 0;
               m_cs_n = '1; m_rd_n = 1; m_we_n = '1; m_bsel_n = '1;
               m_done = 1;
               if (m_cur_rd) m_rdata = m_cur_wide ? mem_din : (mem_din & 16'h00FF);
            end
         end
         if (ended) m_flt = 2 * m_cur_flt;
         else if (m_flt > 0) m_flt--;
         if (acc) begin
            c = m_cfg[req_cs];
            m_busy = 1;
            m_rem = plen(c, req_write);
            m_cur_rd = !req_write;
            m_cur_wide = c[12];
            m_cur_flt = int'(c[11:8]);
            m_last = req_cs;
            m_cs_n = ~(8'd1 << req_cs);
            m_rd_n = req_write;
            if (!req_write) m_we_n = 2'b11;
            else if (!c[12] || c[13]) m_we_n = 2'b10;
            else m_we_n = ~req_be;
            m_bsel_n = (c[12] && c[13]) ? ~req_be : 2'b11;
            m_addr = req_addr;
         end
         if (cfg_we) m_cfg[cfg_idx] = cfg_wdata;
      end
   end

   // per-cycle comparison of every output against the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(mem_cs_n == m_cs_n, "R6 cs_n", mem_cs_n, m_cs_n);
         chk(mem_rd_n == m_rd_n, "R3 R4 rd_n", mem_rd_n, m_rd_n);
         chk(mem_we_n == m_we_n, "R5 R7 we_n", mem_we_n, m_we_n);
         chk(mem_bsel_n == m_bsel_n, "R8 bsel_n", mem_bsel_n, m_bsel_n);
         chk(done == m_done, "R10 done", done, m_done);
         chk(rd_data == m_rdata, "R10 rd_data", rd_data, m_rdata);
         chk(req_ready == m_ready(), "R11 R13 ready", req_ready, m_ready());
         chk(cfg_rdata == m_view(m_cfg[cfg_idx]), "R2 cfg_rdata", cfg_rdata,
             m_view(m_cfg[cfg_idx]));
         if (m_busy) chk(mem_addr == m_addr, "R6 mem_addr", mem_addr, m_addr);
      end
   end

   // ---------------- stimulus helpers ----------------
   int          g_waits;
   int          g_len;
   logic [1:0]  g_we;
   logic [1:0]  g_bsel;

   function automatic logic [15:0] mk(input bit early, input bit whole, input bit wide,
                                      input int flt, input bit en, input int ws);
      return {1'b0, early, whole, wide, 4'(flt), en, 7'(ws)};
   endfunction

   task automatic write_cfg(input logic [2:0] idx, input logic [15:0] w);
      @(negedge clk); #1;
      cfg_we = 1; cfg_idx = idx; cfg_wdata = w;
      @(negedge clk); #1;
      cfg_we = 0;
   endtask

   task automatic read_cfg(input logic [2:0] idx, input logic [15:0] exp, input string tag);
      @(negedge clk); #1;
      cfg_idx = idx;
      #1;
      chk(cfg_rdata == exp, tag, cfg_rdata, exp);
   endtask

   task automatic access(input logic [2:0] cs, input bit wr, input logic [1:0] be,
                         input logic [15:0] addr, input logic [15:0] din,
                         input int exp_len, input string tag);
      g_waits = 0;
      @(negedge clk); #1;
      req_valid = 1; req_cs = cs; req_write = wr; req_be = be;
      req_addr = addr; req_wdata = ~addr; mem_din = din;
      #1;
      while (!req_ready) begin
         g_waits++;
         @(negedge clk); #2;
      end
      @(posedge clk);
      @(negedge clk); #1;
      req_valid = 0;
      g_we = mem_we_n; g_bsel = mem_bsel_n;
      chk(req_ready == 1'b0, "R13 ready during access", req_ready, 0);
      g_len = 0;
      while (mem_cs_n != 8'hFF) begin
         g_len++;
         @(negedge clk); #1;
      end
      if (exp_len >= 0) chk(g_len == exp_len, tag, g_len, exp_len);
      chk(done == 1'b1, "R10 done after strobe", done, 1);
   endtask

   task automatic probe_ready(input logic [2:0] cs, input bit exp, input string tag);
      req_cs = cs;
      #1;
      chk(req_ready == exp, tag, req_ready, exp);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1;
         checks++; fails++;
         $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      @(negedge clk); #1;
      // R1 reset state
      chk(mem_cs_n == 8'hFF, "R1 cs_n", mem_cs_n, 8'hFF);
      chk(mem_rd_n == 1'b1, "R1 rd_n", mem_rd_n, 1);
      chk(mem_we_n == 2'b11, "R1 we_n", mem_we_n, 3);
      chk(mem_bsel_n == 2'b11, "R1 bsel_n", mem_bsel_n, 3);
      chk(done == 1'b0 && rd_data == 16'h0, "R1 done/rd_data", {done, rd_data}, 0);
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
      for (int i = 0; i < 8; i++) read_cfg(3'(i), 16'h0000, "R1 cfg zero");

      // R2 configuration and readback
      write_cfg(3'd0, mk(0, 1, 1, 3, 1, 3));
      write_cfg(3'd1, mk(0, 1, 0, 0, 0, 5));
      write_cfg(3'd2, mk(1, 0, 1, 0, 1, 2));
      write_cfg(3'd3, mk(1, 1, 1, 0, 0, 9));
      write_cfg(3'd5, mk(0, 0, 1, 0, 1, 127));
      write_cfg(3'd6, 16'hFFFF);
      read_cfg(3'd0, mk(0, 1, 1, 3, 1, 3), "R2 readback enabled");
      read_cfg(3'd1, mk(0, 1, 0, 0, 0, 0), "R2 disabled count reads zero");
      read_cfg(3'd6, 16'h7FFF, "R2 bit15 reads zero");

      // R3 standard read, waits on
      access(3'd0, 0, 2'b01, 16'h1234, 16'hBEEF, 9, "R3 std read ws=3");
      chk(rd_data == 16'hBEEF, "R10 read data", rd_data, 16'hBEEF);
      chk(g_bsel == 2'b10, "R8 read byte select", g_bsel, 2'b10);
      // R12 / R11 at the done cycle
      probe_ready(3'd0, 1, "R12 same cs ready");
      probe_ready(3'd4, 0, "R11 other cs blocked");
      access(3'd0, 1, 2'b11, 16'h2222, 16'h0, 8, "R5 write ws=3");
      chk(g_waits == 0, "R12 no wait for same cs", g_waits, 0);
      chk(g_we == 2'b10 && g_bsel == 2'b00, "R8 whole-device write",
          {g_we, g_bsel}, {2'b10, 2'b00});
      chk(rd_data == 16'hBEEF, "R10 write keeps rd_data", rd_data, 16'hBEEF);
      access(3'd4, 0, 2'b11, 16'h4444, 16'h5A5A, 1, "R3 std read no waits");
      chk(g_waits == 5, "R11 float wait 2F-1 after done", g_waits, 5);
      chk(rd_data == 16'h005A, "R9 8-bit upper byte zero", rd_data, 16'h005A);

      // R4 early read, R7 byte-pair writes
      access(3'd2, 0, 2'b11, 16'h0202, 16'hC3C3, 8, "R4 early read ws=2");
      access(3'd2, 1, 2'b10, 16'h0203, 16'h0, 6, "R5 early write ws=2");
      chk(g_we == 2'b01 && g_bsel == 2'b11, "R7 upper lane only", {g_we, g_bsel}, 4'b0111);
      access(3'd2, 1, 2'b01, 16'h0204, 16'h0, 6, "R5 early write ws=2 lane0");
      chk(g_we == 2'b10, "R7 lower lane only", g_we, 2'b10);

      // no-wait cases
      access(3'd1, 0, 2'b10, 16'h0101, 16'hABCD, 1, "R3 std read waits off");
      chk(rd_data == 16'h00CD, "R9 8-bit read", rd_data, 16'h00CD);
      access(3'd1, 1, 2'b10, 16'h0102, 16'h0, 1, "R5 std write waits off");
      chk(g_we == 2'b10 && g_bsel == 2'b11, "R9 8-bit write lane", {g_we, g_bsel}, 4'b1011);
      access(3'd3, 0, 2'b01, 16'h0301, 16'h7777, 2, "R4 early read waits off");
      chk(g_bsel == 2'b10, "R8 read select lane0", g_bsel, 2'b10);
      access(3'd3, 1, 2'b10, 16'h0302, 16'h0, 2, "R5 early write waits off");

      // maximum wait count
      access(3'd5, 0, 2'b11, 16'h0505, 16'h1357, 257, "R3 std read ws=127");
      access(3'd5, 1, 2'b11, 16'h0506, 16'h0, 256, "R5 write ws=127");

      // mixed traffic, checked by the model every cycle
      lfsr = 16'hACE1;
      for (int n = 0; n < 60; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (n % 8 == 0) write_cfg(lfsr[2:0], lfsr & 16'h7F8F);
         access(lfsr[5:3] == 3'd5 ? 3'd6 : lfsr[5:3], lfsr[6], lfsr[8:7],
                lfsr, ~lfsr, -1, "R6 mixed");
      end
      repeat (40) @(negedge clk);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule